// File: doc/BRIEF.md
# Granule Tag Guarded Memory

This block puts a small word-addressed data memory behind a tag check. The memory is split into 16-byte granules, and each granule has a 4-bit tag of its own. Every load and store carries a 64-bit pointer with a tag field. The access goes ahead only when that field equals the stored tag of the granule the word sits in. On a mismatch, a store is dropped, a load returns zero, and a sticky fault record captures the byte address and both tags. Software has no way to mask the fault.

An allocator programs tags through a command port. One command names a first granule, a count and a tag value, and the block writes one granule per cycle until the count runs out. While it works, busy is high and the block ignores every access and every new command. Tag value zero means untagged. Writing zero over a range frees it, so a pointer that still carries the old tag faults from then on. Tags can repeat, so a neighbour granule with the same tag is reachable through the same pointer. Adding to the address part of a pointer leaves its tag field untouched, and the check always uses the granule that the final address lands in.

Top module: `tagged_mem_guard`

## Requirements
- R1: After reset, every granule is untagged (tag 0), every data word is zero, faultFlag is 0, busy is 0 and rdData is 0.
- R2: The pointer tag is taken from accPtr[59:56]. The byte address is accPtr[ADDR_W-1:0], the word index is address bits [ADDR_W-1:2], and the granule index is address bits [ADDR_W-1:4]. All other pointer bits have no effect.
- R3: An access is allowed only when the pointer tag equals the stored tag of the addressed granule. A tag-0 pointer therefore reaches only untagged granules, and a nonzero tag faults on an untagged granule.
- R4: An allowed store writes accWrData to the word at the clock edge. An allowed load puts the word on rdData and raises rdValid for one cycle, in the cycle after the access.
- R5: A store that fails the check leaves memory unchanged. A load that fails the check still raises rdValid, with rdData equal to zero.
- R6: A failed check sets faultFlag from the next cycle. It records the byte address, the pointer tag and the stored tag. The record stays unchanged through later faults until clearFault is pulsed. If a fault arrives in the same cycle as clearFault, the new fault is recorded.
- R7: A command with cmdLen > 0, presented while idle, raises busy in the next cycle and holds it for exactly cmdLen cycles. During that time it writes cmdTag to granules cmdBase, cmdBase+1, and so on, wrapping modulo the granule count. cmdLen = 0 does nothing.
- R8: While busy is high, accesses and commands are ignored: no memory write, no rdValid, no fault, no tag change.
- R9: An access that runs past an allocation into a neighbouring granule holding the same tag is allowed.
- R10: After a range is retagged to 0, a pointer with the old nonzero tag faults on it, and a tag-0 pointer reads the data still held there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Set-tag command strobe |
| cmdBase | input | GIDX_W | First granule to tag |
| cmdLen | input | GIDX_W+1 | Number of granules to tag |
| cmdTag | input | TAG_W | Tag value to write |
| accValid | input | 1 | Access strobe |
| accWrite | input | 1 | 1 = store, 0 = load |
| accPtr | input | PTR_W | Tagged pointer |
| accWrData | input | DATA_W | Store data |
| clearFault | input | 1 | Clears the fault record |
| busy | output | 1 | Tag command in progress |
| rdValid | output | 1 | Load result valid |
| rdData | output | DATA_W | Load result |
| faultFlag | output | 1 | Sticky fault indicator |
| faultAddr | output | ADDR_W | Byte address of the recorded fault |
| faultPtrTag | output | TAG_W | Pointer tag of the recorded fault |
| faultMemTag | output | TAG_W | Stored granule tag of the recorded fault |

## Verification
The assertions check, on every cycle, how the fault record behaves: it is set after a failed check and holds until cleared. They also check that a failed load returns zero, and that the command sequencer starts, steps one granule per cycle and stops on time. Only the bench scenarios can show that tags actually end up in the right granules, including across wrap-around. The same goes for a dropped store leaving old data in place, accesses and commands having no effect during busy, same-tag neighbours being reachable, and freed ranges trapping stale pointers.

// File: rtl/tagchk_pkg.sv
`timescale 1ns/1ps
package tagchk_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic tagWr;     // write one granule tag this cycle
    logic accFire;   // an access is accepted
    logic storeEn;   // accepted store that passed the check
    logic loadEn;    // accepted load (pass or fail)
    logic faultSet;  // accepted access failed the check
  } strobe_t;
endpackage

// File: rtl/tagchk_ctrl.sv
`timescale 1ns/1ps
module tagchk_ctrl
  import tagchk_pkg::*;
#(
  parameter int GIDX_W = 4,
  parameter int TAG_W  = 4,
  localparam int LEN_W = GIDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [GIDX_W-1:0] cmdBase,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              tagMatch,
  output strobe_t           st,
  output logic [GIDX_W-1:0] tagIdx,
  output logic [TAG_W-1:0]  tagVal,
  output logic              busy
);
  logic              busyQ;
  logic [GIDX_W-1:0] idxQ;
  logic [LEN_W-1:0]  leftQ;
  logic [TAG_W-1:0]  tagQ;
  logic              cmdStart;

  assign cmdStart = !busyQ && cmdValid && (cmdLen != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      leftQ <= '0;
      tagQ  <= '0;
    end else if (busyQ) begin
      idxQ  <= idxQ + 1'b1;
      leftQ <= leftQ - 1'b1;
      if (leftQ == LEN_W'(1)) busyQ <= 1'b0;
    end else if (cmdStart) begin
      busyQ <= 1'b1;
      idxQ  <= cmdBase;
      leftQ <= cmdLen;
      tagQ  <= cmdTag;
    end
  end

  always_comb begin
    st.tagWr    = busyQ;
    st.accFire  = accValid && !busyQ;
    st.storeEn  = st.accFire && accWrite && tagMatch;
    st.loadEn   = st.accFire && !accWrite;
    st.faultSet = st.accFire && !tagMatch;
  end

  assign tagIdx = idxQ;
  assign tagVal = tagQ;
  assign busy   = busyQ;

  assert_cmd_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> busyQ);
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && leftQ == LEN_W'(1)) |=> !busyQ);
  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && leftQ != LEN_W'(1)) |=> (busyQ && idxQ == GIDX_W'($past(idxQ) + 1'b1)));
endmodule

// File: rtl/tagchk_dpath.sv
`timescale 1ns/1ps
module tagchk_dpath
  import tagchk_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int GRAN_LSB = 4,
  localparam int WORD_LSB = $clog2(DATA_W / 8),
  localparam int GIDX_W   = ADDR_W - GRAN_LSB,
  localparam int WIDX_W   = ADDR_W - WORD_LSB,
  localparam int NGRAN    = 1 << GIDX_W,
  localparam int NWORD    = 1 << WIDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [GIDX_W-1:0] tagIdx,
  input  logic [TAG_W-1:0]  tagVal,
  input  logic [TAG_W-1:0]  ptrTag,
  input  logic [ADDR_W-1:0] ptrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clearFault,
  output logic              tagMatch,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              faultFlag,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [TAG_W-1:0]  faultPtrTag,
  output logic [TAG_W-1:0]  faultMemTag
);
  logic [TAG_W-1:0]  tagArr  [NGRAN];
  logic [DATA_W-1:0] dataMem [NWORD];
  logic [GIDX_W-1:0] gIdx;
  logic [WIDX_W-1:0] wIdx;
  logic [TAG_W-1:0]  granTag;

  assign gIdx     = ptrAddr[ADDR_W-1:GRAN_LSB];
  assign wIdx     = ptrAddr[ADDR_W-1:WORD_LSB];
  assign granTag  = tagArr[gIdx];
  assign tagMatch = (ptrTag == granTag);

  // one tag register per granule
  for (genvar g = 0; g < NGRAN; g++) begin : gTag
    logic [TAG_W-1:0] tagQ;
    always_ff @(posedge clk) begin
      if (!rstN) tagQ <= '0;
      else if (st.tagWr && tagIdx == GIDX_W'(g)) tagQ <= tagVal;
    end
    assign tagArr[g] = tagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWORD; i++) dataMem[i] <= '0;
    end else if (st.storeEn) begin
      dataMem[wIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.loadEn;
      if (st.loadEn) rdData <= tagMatch ? dataMem[wIdx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultFlag   <= 1'b0;
      faultAddr   <= '0;
      faultPtrTag <= '0;
      faultMemTag <= '0;
    end else if (st.faultSet && (clearFault || !faultFlag)) begin
      faultFlag   <= 1'b1;
      faultAddr   <= ptrAddr;
      faultPtrTag <= ptrTag;
      faultMemTag <= granTag;
    end else if (clearFault) begin
      faultFlag <= 1'b0;
    end
  end

  assert_fault_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.faultSet |=> faultFlag);
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !clearFault) |=> (faultFlag && $stable(faultAddr)
      && $stable(faultPtrTag) && $stable(faultMemTag)));
  assert_zero_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadEn && !tagMatch) |=> (rdValid && rdData == '0));
endmodule

// File: rtl/tagged_mem_guard.sv
`timescale 1ns/1ps
module tagged_mem_guard
  import tagchk_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int PTR_W    = 64,
  parameter int TAG_LSB  = 56,
  parameter int GRAN_LSB = 4,
  localparam int GIDX_W   = ADDR_W - GRAN_LSB,
  localparam int LEN_W    = GIDX_W + 1,
  localparam int WORD_LSB = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [GIDX_W-1:0] cmdBase,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [PTR_W-1:0]  accPtr,
  input  logic [DATA_W-1:0] accWrData,
  input  logic              clearFault,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              faultFlag,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [TAG_W-1:0]  faultPtrTag,
  output logic [TAG_W-1:0]  faultMemTag
);
  strobe_t           st;
  logic              tagMatch;
  logic [GIDX_W-1:0] tagIdx;
  logic [TAG_W-1:0]  tagVal;
  logic              unusedPtrBits;

  assign unusedPtrBits = ^{accPtr[PTR_W-1:TAG_LSB+TAG_W], accPtr[TAG_LSB-1:ADDR_W],
                           accPtr[WORD_LSB-1:0]};

  tagchk_ctrl #(.GIDX_W(GIDX_W), .TAG_W(TAG_W)) i_ctrl (
    .clk, .rstN, .cmdValid, .cmdBase, .cmdLen, .cmdTag,
    .accValid, .accWrite, .tagMatch, .st, .tagIdx, .tagVal, .busy
  );

  tagchk_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
                 .GRAN_LSB(GRAN_LSB)) i_dpath (
    .clk, .rstN, .st, .tagIdx, .tagVal,
    .ptrTag(accPtr[TAG_LSB+TAG_W-1:TAG_LSB]),
    .ptrAddr(accPtr[ADDR_W-1:0]),
    .wrData(accWrData), .clearFault, .tagMatch,
    .rdValid, .rdData, .faultFlag, .faultAddr, .faultPtrTag, .faultMemTag
  );
endmodule

// File: tb/test_tagged_mem_guard.sv
`timescale 1ns/1ps
module test_tagged_mem_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdBase = '0;
  logic [4:0]  cmdLen = '0;
  logic [3:0]  cmdTag = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [63:0] accPtr = '0;
  logic [31:0] accWrData = '0;
  logic        clearFault = 1'b0;
  logic        busy, rdValid, faultFlag;
  logic [31:0] rdData;
  logic [7:0]  faultAddr;
  logic [3:0]  faultPtrTag, faultMemTag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tagged_mem_guard i_tagged_mem_guard (
    .clk, .rstN, .cmdValid, .cmdBase, .cmdLen, .cmdTag, .accValid, .accWrite,
    .accPtr, .accWrData, .clearFault, .busy, .rdValid, .rdData, .faultFlag,
    .faultAddr, .faultPtrTag, .faultMemTag
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkPtr(input logic [3:0] tag, input logic [7:0] addr);
    return {4'h0, tag, 48'h0, addr};
  endfunction

  // all tasks start and end on a falling edge
  task automatic access(input logic wr, input logic [63:0] ptr, input logic [31:0] d);
    accValid = 1'b1; accWrite = wr; accPtr = ptr; accWrData = d;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic loadExpect(input string req, input logic [63:0] ptr,
                            input logic [31:0] exp, input logic expFault);
    access(1'b0, ptr, '0);
    chk(req, rdValid, 1'b1);
    chk(req, rdData, exp);
    chk(req, faultFlag, expFault);
  endtask

  task automatic startCmd(input logic [3:0] b, input logic [4:0] l, input logic [3:0] t);
    cmdValid = 1'b1; cmdBase = b; cmdLen = l; cmdTag = t;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulseClear();
    clearFault = 1'b1;
    @(negedge clk);
    clearFault = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 busy", busy, 1'b0);
    chk("R1 fault", faultFlag, 1'b0);
    chk("R1 rdData", rdData, 32'h0);
    loadExpect("R1 untagged tag0 load", mkPtr(4'h0, 8'h84), 32'h0, 1'b0);
  endtask

  task automatic tTagAndAccess();
    startCmd(4'd2, 5'd3, 4'h5);
    chk("R7 busy rises", busy, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 busy held len", busy, 1'b1);
    @(negedge clk);
    chk("R7 busy drops", busy, 1'b0);
    access(1'b1, mkPtr(4'h5, 8'h20), 32'hA5A5_0001);
    chk("R4 store no fault", faultFlag, 1'b0);
    loadExpect("R4 R3 matching load", mkPtr(4'h5, 8'h20), 32'hA5A5_0001, 1'b0);
    loadExpect("R7 last granule tagged", mkPtr(4'h5, 8'h40), 32'h0, 1'b0);
  endtask

  task automatic tPtrBits();
    access(1'b1, 64'hF500_00FF_FFFF_FF27, 32'hBEEF_0002);
    chk("R2 dirty ptr no fault", faultFlag, 1'b0);
    loadExpect("R2 clean ptr readback", mkPtr(4'h5, 8'h24), 32'hBEEF_0002, 1'b0);
  endtask

  task automatic tMismatch();
    loadExpect("R5 failed load zero", mkPtr(4'h3, 8'h20), 32'h0, 1'b1);
    chk("R6 fault addr", faultAddr, 8'h20);
    chk("R6 fault ptr tag", faultPtrTag, 4'h3);
    chk("R6 fault mem tag", faultMemTag, 4'h5);
    access(1'b1, mkPtr(4'h7, 8'h28), 32'hDEAD_0003);
    chk("R6 record kept addr", faultAddr, 8'h20);
    chk("R6 record kept tag", faultPtrTag, 4'h3);
    pulseClear();
    chk("R6 cleared", faultFlag, 1'b0);
    loadExpect("R5 store suppressed", mkPtr(4'h5, 8'h28), 32'h0, 1'b0);
    loadExpect("R3 tag0 on tagged faults", mkPtr(4'h0, 8'h20), 32'h0, 1'b1);
    pulseClear();
  endtask

  task automatic tRepeatTag();
    startCmd(4'd5, 5'd1, 4'h5);
    waitIdle();
    access(1'b1, mkPtr(4'h5, 8'h5C), 32'h1234_0004);
    loadExpect("R9 same tag neighbour", mkPtr(4'h5, 8'h5C), 32'h1234_0004, 1'b0);
    loadExpect("R3 nonzero on untagged", mkPtr(4'h5, 8'h60), 32'h0, 1'b1);
    chk("R3 mem tag 0", faultMemTag, 4'h0);
    pulseClear();
  endtask

  task automatic tFree();
    startCmd(4'd2, 5'd3, 4'h0);
    waitIdle();
    loadExpect("R10 stale ptr faults", mkPtr(4'h5, 8'h20), 32'h0, 1'b1);
    pulseClear();
    loadExpect("R10 tag0 reads freed", mkPtr(4'h0, 8'h20), 32'hA5A5_0001, 1'b0);
  endtask

  task automatic tBusyBlocks();
    startCmd(4'd14, 5'd4, 4'h9);
    chk("R8 busy", busy, 1'b1);
    access(1'b1, mkPtr(4'h0, 8'h40), 32'hCAFE_0005);
    access(1'b0, mkPtr(4'h0, 8'h40), '0);
    chk("R8 no rdValid", rdValid, 1'b0);
    chk("R8 no fault", faultFlag, 1'b0);
    startCmd(4'd4, 5'd1, 4'h6);
    chk("R7 busy len4", busy, 1'b1);
    @(negedge clk);
    chk("R7 busy done", busy, 1'b0);
    loadExpect("R8 store ignored", mkPtr(4'h0, 8'h40), 32'h0, 1'b0);
    loadExpect("R7 wrap g14", mkPtr(4'h9, 8'hE0), 32'h0, 1'b0);
    loadExpect("R7 wrap g15", mkPtr(4'h9, 8'hF0), 32'h0, 1'b0);
    loadExpect("R7 wrap g0", mkPtr(4'h9, 8'h00), 32'h0, 1'b0);
    loadExpect("R7 wrap g1", mkPtr(4'h9, 8'h10), 32'h0, 1'b0);
    loadExpect("R7 g2 untouched", mkPtr(4'h9, 8'h20), 32'h0, 1'b1);
    pulseClear();
  endtask

  task automatic tZeroLen();
    startCmd(4'd3, 5'd0, 4'h7);
    chk("R7 len0 no busy", busy, 1'b0);
    loadExpect("R7 len0 no tag", mkPtr(4'h0, 8'h30), 32'h0, 1'b0);
  endtask

  task automatic tClearRace();
    loadExpect("R6 setup fault", mkPtr(4'h9, 8'h20), 32'h0, 1'b1);
    clearFault = 1'b1;
    access(1'b0, mkPtr(4'h3, 8'h70), '0);
    clearFault = 1'b0;
    chk("R6 race flag", faultFlag, 1'b1);
    chk("R6 race addr", faultAddr, 8'h70);
    chk("R6 race ptr tag", faultPtrTag, 4'h3);
    chk("R6 race mem tag", faultMemTag, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTagAndAccess();
    tPtrBits();
    tMismatch();
    tRepeatTag();
    tFree();
    tBusyBlocks();
    tZeroLen();
    tClearRace();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule